// File: doc/BRIEF.md
# PCI Interrupt Map and Gate

The block sits between 32 level-sensitive PCI interrupt lines and the downstream interrupt controller. The lines are split into eight groups of four. Each group has one 32-bit map register. Bit 31 of that register is an enable that lets the four lines through. The remaining bits hold fixed routing information that software can read but cannot change.

A plain register port gives access to the map registers. Address decode is done inside the block; the caller only presents the in-window byte offset. Read data is a combinational function of the offset. Outputs are registered, so every output line is a clean flop.

The asynchronous power-up reset loads the full default value of every register. A separate one-cycle clear pulse drops only the enables and leaves the routing bits as they were.

Top module: `pci_intr_map`

## Requirements
- R1: There are 32 input lines and 8 map registers. Line n is governed by register floor(n/4), so lines 4i to 4i+3 belong to register i.
- R2: Register i is reached at byte offset 8*i+4, which means offset bit 2 is set and bits 5:3 hold i. `bus_rdata_o` shows its value in the same cycle. At any offset with bit 2 clear, reads return 0 and writes change nothing.
- R3: After `rst_ni` is asserted, register i reads 0x7C0 | (i<<2), with bits 10:6 = 0x1F, bits 4:2 = i, and all other bits 0. The enable bit 31 is therefore 0 and every `irq_o` bit is 0.
- R4: A write to register i loads bit 31 from `bus_wdata_i[31]`. Bits 30:0 of the register are never changed by a write.
- R5: While the group enable is 1, `irq_o[n]` equals the value `irq_i[n]` had one clock earlier.
- R6: While the group enable is 0, `irq_o[n]` is 0 one clock later, whatever `irq_i[n]` is. The output is forced low, not held at its last value.
- R7: A one-cycle `en_clr_i` clears bit 31 of all eight registers at that clock edge and leaves bits 30:0 unchanged. If a write arrives in the same cycle, the clear wins.
- R8: A write that changes an enable takes effect on the register at the write's clock edge and on `irq_o` at the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-up reset |
| en_clr_i | input | 1 | One-cycle pulse that clears all group enables |
| bus_we_i | input | 1 | Write strobe for the register port |
| bus_addr_i | input | 6 | Byte offset within the 0x40-byte window |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` (combinational) |
| irq_i | input | 32 | Incoming PCI interrupt levels |
| irq_o | output | 32 | Gated, registered interrupt levels |

## Verification
The gating path is driven with several patterns against different enable masks:
- All groups on with a checkerboard input shows that levels pass straight through, bit for bit.
- All groups off with every input high shows that outputs are forced low.
- A single low or high group shows the line-to-register mapping at both ends.
- Alternating group masks over a counting pattern would expose a swapped or shifted group.

Directed cases then cover the rest:
- the reset values and the dead lower word;
- a write of all ones to the routing bits;
- the clear pulse colliding with a write;
- the one-clock output latency, sampled just before and just after the edge.

// File: rtl/pim_pkg.sv
package pim_pkg;
  localparam int DATA_W = 32;
  localparam int EN_BIT = 31;
  localparam int LIVE_BIT = 2;
  localparam int IDX_LSB = 3;

  // fixed routing contents of map register idx
  function automatic logic [DATA_W-1:0] map_default(input int unsigned idx);
    logic [DATA_W-1:0] v;
    v = '0;
    v[10:6] = 5'h1F;
    v[4:2]  = idx[2:0];
    return v;
  endfunction
endpackage

// File: rtl/pim_decode.sv
module pim_decode #(
  parameter int N_GRP  = 8,
  parameter int IDX_W  = 3,
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              live_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [N_GRP-1:0]  wr_hit_o
);
  import pim_pkg::*;

  assign live_o = addr_i[LIVE_BIT];
  assign idx_o  = addr_i[ADDR_W-1:IDX_LSB];

  always_comb begin
    wr_hit_o = '0;
    if (we_i && live_o) wr_hit_o[idx_o] = 1'b1;
  end

  // R2
  single_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_hit_o));
endmodule

// File: rtl/pim_regs.sv
module pim_regs #(
  parameter int N_GRP = 8,
  parameter int IDX_W = 3
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       clr_i,
  input  logic [N_GRP-1:0]           wr_hit_i,
  input  logic                       wr_en_bit_i,
  input  logic                       live_i,
  input  logic [IDX_W-1:0]           idx_i,
  output logic [N_GRP-1:0]           en_o,
  output logic [pim_pkg::DATA_W-1:0] rdata_o
);
  import pim_pkg::*;

  logic [N_GRP-1:0] en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= '0;
    end else if (clr_i) begin
      en_q <= '0;  // clear wins over a same-cycle write
    end else begin
      for (int i = 0; i < N_GRP; i++)
        if (wr_hit_i[i]) en_q[i] <= wr_en_bit_i;
    end
  end

  assign en_o = en_q;

  always_comb begin
    rdata_o = '0;
    if (live_i) begin
      rdata_o = map_default(int'(idx_i));
      rdata_o[EN_BIT] = en_q[idx_i];
    end
  end

  // R7
  clr_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (en_o == '0));

  // R2
  no_hit_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && wr_hit_i == '0) |=> $stable(en_o));

  for (genvar g = 0; g < N_GRP; g++) begin : g_chk
    // R4
    wr_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!clr_i && wr_hit_i[g]) |=> (en_o[g] == $past(wr_en_bit_i)));
  end
endmodule

// File: rtl/pim_gate.sv
module pim_gate #(
  parameter int N_LINES = 32,
  parameter int LPG     = 4,
  parameter int N_GRP   = N_LINES / LPG
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_GRP-1:0]   en_i,
  input  logic [N_LINES-1:0] irq_i,
  output logic [N_LINES-1:0] irq_o
);
  for (genvar n = 0; n < N_LINES; n++) begin : g_line
    localparam int G = n / LPG;
    logic q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= 1'b0;
      else         q <= en_i[G] & irq_i[n];
    end

    assign irq_o[n] = q;

    // R5
    pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      en_i[G] |=> (irq_o[n] == $past(irq_i[n])));

    // R6
    force_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i[G] |=> !irq_o[n]);
  end
endmodule

// File: rtl/pci_intr_map.sv
module pci_intr_map #(
  parameter int N_LINES = 32,
  parameter int LPG     = 4,
  localparam int N_GRP  = N_LINES / LPG,
  localparam int IDX_W  = $clog2(N_GRP),
  localparam int ADDR_W = IDX_W + pim_pkg::IDX_LSB
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       en_clr_i,
  input  logic                       bus_we_i,
  input  logic [ADDR_W-1:0]          bus_addr_i,
  input  logic [pim_pkg::DATA_W-1:0] bus_wdata_i,
  output logic [pim_pkg::DATA_W-1:0] bus_rdata_o,
  input  logic [N_LINES-1:0]         irq_i,
  output logic [N_LINES-1:0]         irq_o
);
  import pim_pkg::*;

  logic             live;
  logic [IDX_W-1:0] idx;
  logic [N_GRP-1:0] wr_hit;
  logic [N_GRP-1:0] en;

  pim_decode #(.N_GRP(N_GRP), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_dec (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (bus_we_i),
    .addr_i   (bus_addr_i),
    .live_o   (live),
    .idx_o    (idx),
    .wr_hit_o (wr_hit)
  );

  pim_regs #(.N_GRP(N_GRP), .IDX_W(IDX_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (en_clr_i),
    .wr_hit_i    (wr_hit),
    .wr_en_bit_i (bus_wdata_i[EN_BIT]),
    .live_i      (live),
    .idx_i       (idx),
    .en_o        (en),
    .rdata_o     (bus_rdata_o)
  );

  pim_gate #(.N_LINES(N_LINES), .LPG(LPG), .N_GRP(N_GRP)) u_gate (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en),
    .irq_i  (irq_i),
    .irq_o  (irq_o)
  );
endmodule

// File: tb/tb_pci_intr_map.sv
module tb_pci_intr_map;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_clr_i = 1'b0;
  logic        bus_we_i = 1'b0;
  logic [5:0]  bus_addr_i = '0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic [31:0] irq_i = '0;
  logic [31:0] irq_o;

  int n_run = 0;
  int n_fail = 0;

  always #2 clk_i = ~clk_i;

  pci_intr_map dut (.*);

  // {group enable mask, input levels, expected outputs}
  localparam logic [71:0] VEC [6] = '{
    {8'hFF, 32'hA5A5_5A5A, 32'hA5A5_5A5A},
    {8'h00, 32'hFFFF_FFFF, 32'h0000_0000},
    {8'h01, 32'hFFFF_FFFF, 32'h0000_000F},
    {8'h80, 32'hFFFF_FFFF, 32'hF000_0000},
    {8'h55, 32'hFFFF_FFFF, 32'h0F0F_0F0F},
    {8'hAA, 32'h1234_5678, 32'h1030_5070}
  };

  function automatic logic [31:0] dflt(input int i);
    return 32'h7C0 | (32'(i) << 2);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk_i);
    bus_we_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk_i);
    bus_we_i = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    bus_addr_i = a;
    #1 d = bus_rdata_o;
  endtask

  task automatic report;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #400000;
    n_run++; n_fail++;
    $display("FAIL R5 watchdog act=hung exp=done");
    report();
  end

  initial begin
    logic [31:0] r;
    irq_i = 32'hFFFF_FFFF;
    #9 rst_ni = 1'b1;
    @(negedge clk_i);
    // R3 reset values, R2 lower word zero
    for (int i = 0; i < 8; i++) begin
      rd(6'(i * 8 + 4), r); check($sformatf("R3 reg%0d", i), r, dflt(i));
      rd(6'(i * 8), r);     check($sformatf("R2 low%0d", i), r, 32'h0);
    end
    check("R3 irq_o after reset", irq_o, 32'h0);

    // R1 R5 R6 vector table
    foreach (VEC[k]) begin
      for (int i = 0; i < 8; i++) wr(6'(i * 8 + 4), {VEC[k][64 + i], 31'h0});
      @(negedge clk_i); irq_i = VEC[k][63:32];
      @(negedge clk_i); @(negedge clk_i);
      check($sformatf("R1 R5 R6 vec%0d", k), irq_o, VEC[k][31:0]);
    end

    // R4 routing bits are write-protected
    wr(6'h0C, 32'h7FFF_FFFF);
    rd(6'h0C, r); check("R4 write ones, en off", r, dflt(1));
    wr(6'h0C, 32'hFFFF_FFFF);
    rd(6'h0C, r); check("R4 write ones, en on", r, dflt(1) | 32'h8000_0000);

    // R2 lower-word write ignored, observed at irq_o and readback
    for (int i = 0; i < 8; i++) wr(6'(i * 8 + 4), 32'h0);
    irq_i = 32'hFFFF_FFFF;
    wr(6'h10, 32'h8000_0000);
    @(negedge clk_i);
    check("R2 low write irq_o", irq_o, 32'h0);
    rd(6'h14, r); check("R2 low write readback", r, dflt(2));

    // R8 enable takes effect one edge after the write edge
    @(negedge clk_i);
    bus_we_i = 1'b1; bus_addr_i = 6'h14; bus_wdata_i = 32'h8000_0000;
    @(negedge clk_i);
    bus_we_i = 1'b0;
    check("R8 not yet", irq_o, 32'h0);
    @(negedge clk_i);
    check("R8 enabled", irq_o, 32'h0000_0F00);

    // R5 one-clock latency on an input change
    irq_i = 32'h0000_0500;
    @(posedge clk_i); #0.5;
    check("R5 after edge", irq_o, 32'h0000_0500);
    @(negedge clk_i);
    irq_i = 32'h0000_0A00;
    #1 check("R5 before edge", irq_o, 32'h0000_0500);

    // R7 clear pulse beats a same-cycle write, keeps routing bits
    wr(6'h3C, 32'h8000_0000);
    irq_i = 32'hFFFF_FFFF;
    @(negedge clk_i);
    en_clr_i = 1'b1; bus_we_i = 1'b1; bus_addr_i = 6'h04; bus_wdata_i = 32'h8000_0000;
    @(negedge clk_i);
    en_clr_i = 1'b0; bus_we_i = 1'b0;
    rd(6'h04, r); check("R7 clr beats write", r, dflt(0));
    rd(6'h3C, r); check("R7 clr reg7", r, dflt(7));
    rd(6'h14, r); check("R7 clr reg2", r, dflt(2));
    @(negedge clk_i);
    check("R7 R6 outputs forced low", irq_o, 32'h0);

    report();
  end
endmodule